// File: doc/BRIEF.md
# Flag-setting compare unit

This block evaluates 32-bit arithmetic and logical operations for a processor datapath and keeps the four condition flags (negative, zero, carry, overflow) in a register. Each cycle in which `valid_i` is high, it applies the operation chosen by `op_i` to operands `a_i` and `b_i`. The logical operations also take a carry bit supplied by an external shifter. The result is presented combinationally on `result_o`. A write strobe on `result_wr_o` tells the register file whether the result is to be kept.

There are four flag-only operations: compare, compare-negated, bit test and equivalence test. They always update the flags and never raise the write strobe. The four data operations are add, subtract, AND and XOR. They always produce a result, but they change the flags only when the set-flags bit `set_flags_i` is high. Subtraction is carried out as A plus the inverted B plus one, in the same adder used for addition. As a result, carry after a subtract means that no borrow occurred.

Top module: `flag_cmp_unit`

## Requirements
- R1: While `rst_ni` is low, `flags_o` is 0. `flags_o` is packed as bit 3 = N, bit 2 = Z, bit 1 = C and bit 0 = V.
- R2: Compare (`op_i`=3'b100) updates the flags from A-B. N = bit 31, Z = (A-B==0), C = (A >= B unsigned) and V = signed overflow of the subtraction. `result_wr_o` stays low.
- R3: Compare-negated (`op_i`=3'b101) updates the flags from A+B. C = carry out of bit 31 and V = carry into bit 31 XOR carry out of bit 31. `result_wr_o` stays low.
- R4: Bit test (`op_i`=3'b110) updates N and Z from A AND B, copies `shift_c_i` into C and leaves V unchanged. `result_wr_o` stays low.
- R5: Equivalence test (`op_i`=3'b111) updates N and Z from A XOR B, copies `shift_c_i` into C and leaves V unchanged. `result_wr_o` stays low.
- R6: Add (3'b000) and subtract (3'b001) drive `result_o` = A+B or A-B and raise `result_wr_o`. When `set_flags_i`=1, the flags update with the rules of R3 and R2 respectively.
- R7: AND (3'b010) and XOR (3'b011) drive `result_o` = A&B or A^B and raise `result_wr_o`. When `set_flags_i`=1, the flags update with the rules of R4 and R5 respectively.
- R8: When `set_flags_i`=0, a data operation (codes 3'b000 to 3'b011) leaves all four flags unchanged.
- R9: When `valid_i`=0, the flags hold and `result_wr_o` is low.
- R10: A compare of 0x7FFFFFFF with 0xFFFFFFFF gives N=1, Z=0, C=0, V=1. A compare-negated of 0x7FFFFFFF with 0xFFFFFFFC gives N=0, Z=0, C=1, V=0.
- R11: The flags change on the rising clock edge that samples a valid operation, and are visible on `flags_o` after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Operation select |
| set_flags_i | input | 1 | Allow data operations to update the flags |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand, already shifted |
| shift_c_i | input | 1 | Carry out of the external shifter |
| result_o | output | 32 | Combinational operation result |
| result_wr_o | output | 1 | Result is to be written back |
| flags_o | output | 4 | Stored flags {N,Z,C,V} |

## Verification
A wrong carry-in or a wrong operand inversion in the shared adder shows up on `result_o` in the same cycle as the operation, for add and subtract. For the flag-only operations, the same fault appears one edge later as a C or V bit that disagrees with the unsigned or signed ordering of the operands. A wrong update enable is seen in two ways: flags that move after an add without S or after an idle cycle, or a V bit that changes after a test. These faults are visible on `flags_o` right after the offending edge. They stay visible until the next flag-setting operation, so the sweep checks the flags after every operation.

// File: rtl/flag_cmp_pkg.sv
package flag_cmp_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_AND = 3'b010,
    OP_XOR = 3'b011,
    OP_CMP = 3'b100,
    OP_CMN = 3'b101,
    OP_TST = 3'b110,
    OP_TEQ = 3'b111
  } fcu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } fcu_flags_t;
endpackage

// File: rtl/fcu_arith.sv
module fcu_arith #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              c_o,
  output logic              v_o
);
  localparam int LOW_W = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic [LOW_W:0]    low_sum;
  logic [1:0]        top_sum;
  logic              c_into_msb;

  // subtract as a + ~b + 1
  assign b_eff      = sub_i ? ~b_i : b_i;
  assign low_sum    = {1'b0, a_i[LOW_W-1:0]} + {1'b0, b_eff[LOW_W-1:0]} + {{LOW_W{1'b0}}, sub_i};
  assign c_into_msb = low_sum[LOW_W];
  assign top_sum    = {1'b0, a_i[DATA_W-1]} + {1'b0, b_eff[DATA_W-1]} + {1'b0, c_into_msb};

  assign sum_o = {top_sum[0], low_sum[LOW_W-1:0]};
  assign c_o   = top_sum[1];
  assign v_o   = top_sum[1] ^ c_into_msb;
endmodule

// File: rtl/fcu_logic.sv
module fcu_logic #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              xor_i,
  output logic [DATA_W-1:0] res_o
);
  assign res_o = xor_i ? (a_i ^ b_i) : (a_i & b_i);
endmodule

// File: rtl/fcu_flag_reg.sv
module fcu_flag_reg
  import flag_cmp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       upd_i,
  input  fcu_flags_t next_i,
  output fcu_flags_t flags_o
);
  fcu_flags_t flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flags_q <= '0;
    else if (upd_i) flags_q <= next_i;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/flag_cmp_unit.sv
module flag_cmp_unit
  import flag_cmp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic              set_flags_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              shift_c_i,
  output logic [DATA_W-1:0] result_o,
  output logic              result_wr_o,
  output logic [3:0]        flags_o
);
  fcu_op_e           op;
  logic              is_arith, is_sub, is_flag_only, upd;
  logic [DATA_W-1:0] arith_res, logic_res;
  logic              arith_c, arith_v;
  fcu_flags_t        flags_q, flags_d;

  assign op = fcu_op_e'(op_i);

  always_comb begin
    is_arith = 1'b0;
    is_sub   = 1'b0;
    unique case (op)
      OP_ADD, OP_CMN: is_arith = 1'b1;
      OP_SUB, OP_CMP: begin is_arith = 1'b1; is_sub = 1'b1; end
      default: ;
    endcase
  end

  assign is_flag_only = op_i[2];

  fcu_arith #(.DATA_W(DATA_W)) u_arith (
    .a_i   (a_i),
    .b_i   (b_i),
    .sub_i (is_sub),
    .sum_o (arith_res),
    .c_o   (arith_c),
    .v_o   (arith_v)
  );

  fcu_logic #(.DATA_W(DATA_W)) u_logic (
    .a_i   (a_i),
    .b_i   (b_i),
    .xor_i (op_i[0]),
    .res_o (logic_res)
  );

  assign result_o    = is_arith ? arith_res : logic_res;
  assign result_wr_o = valid_i && !is_flag_only;

  // logical ops take C from the shifter and keep V
  always_comb begin
    flags_d.n = result_o[DATA_W-1];
    flags_d.z = (result_o == '0);
    flags_d.c = is_arith ? arith_c : shift_c_i;
    flags_d.v = is_arith ? arith_v : flags_q.v;
  end

  assign upd = valid_i && (is_flag_only || set_flags_i);

  fcu_flag_reg u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .upd_i   (upd),
    .next_i  (flags_d),
    .flags_o (flags_q)
  );

  assign flags_o = flags_q;
endmodule

// File: rtl/flag_cmp_unit_chk.sv
module flag_cmp_unit_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [2:0]        op_i,
  input logic              set_flags_i,
  input logic [DATA_W-1:0] result_o,
  input logic              result_wr_o,
  input logic              shift_c_i,
  input logic [3:0]        flags_o
);
  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(flags_o));

  // R9
  idle_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !result_wr_o);

  // R8
  no_s_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !op_i[2] && !set_flags_i) |=> $stable(flags_o));

  // R2
  zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i[2]) |=> (flags_o[2] == ($past(result_o) == '0)));

  // R2
  neg_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i[2]) |=> (flags_o[3] == $past(result_o[DATA_W-1])));

  // R4
  test_v_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i[2] && op_i[1]) |=> (flags_o[0] == $past(flags_o[0])));

  // R5
  test_c_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i[2] && op_i[1]) |=> (flags_o[1] == $past(shift_c_i)));
endmodule

bind flag_cmp_unit flag_cmp_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .op_i        (op_i),
  .set_flags_i (set_flags_i),
  .result_o    (result_o),
  .result_wr_o (result_wr_o),
  .shift_c_i   (shift_c_i),
  .flags_o     (flags_o)
);

// File: tb/flag_cmp_unit_tb.sv
module flag_cmp_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [2:0]   op_i = '0;
  logic         set_flags_i = 1'b0;
  logic [W-1:0] a_i = '0;
  logic [W-1:0] b_i = '0;
  logic         shift_c_i = 1'b0;
  logic [W-1:0] result_o;
  logic         result_wr_o;
  logic [3:0]   flags_o;

  int checks = 0;
  int errors = 0;
  logic [3:0] exp_flags = '0;
  logic [W-1:0] vals [9];

  always #(CLK_PERIOD/2) clk = ~clk;

  flag_cmp_unit #(.DATA_W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .set_flags_i(set_flags_i), .a_i(a_i), .b_i(b_i), .shift_c_i(shift_c_i),
    .result_o(result_o), .result_wr_o(result_wr_o), .flags_o(flags_o)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (op=%b a=%h b=%h s=%b)",
               req, act, exp, op_i, a_i, b_i, set_flags_i);
    end
  endtask

  function automatic string req_of(input logic [2:0] op, input logic s);
    case (op)
      3'b100: return "R2";
      3'b101: return "R3";
      3'b110: return "R4";
      3'b111: return "R5";
      3'b000, 3'b001: return s ? "R6" : "R8";
      default: return s ? "R7" : "R8";
    endcase
  endfunction

  task automatic run_op(input logic [2:0] op, input logic s, input logic [W-1:0] a,
                        input logic [W-1:0] b, input logic sc, input logic vld);
    logic [W:0]   wide;
    logic [W-1:0] r;
    logic [3:0]   nxt;
    logic         cf, vf;
    @(negedge clk);
    op_i = op; set_flags_i = s; a_i = a; b_i = b; shift_c_i = sc; valid_i = vld;
    case (op[1:0] == 2'b00 && !op[2] ? 3'd0 : op)
      3'd0, 3'b101: begin
        wide = {1'b0, a} + {1'b0, b};
        r = wide[W-1:0]; cf = wide[W];
        vf = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
      end
      3'b001, 3'b100: begin
        r = a - b; cf = (a >= b);
        vf = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]);
      end
      3'b010, 3'b110: begin r = a & b; cf = sc; vf = exp_flags[0]; end
      default: begin r = a ^ b; cf = sc; vf = exp_flags[0]; end
    endcase
    nxt = {r[W-1], (r == '0), cf, vf};
    #1;
    if (!vld) check("R9", {31'b0, result_wr_o}, '0);
    else begin
      check(req_of(op, s), {31'b0, result_wr_o}, {31'b0, !op[2]});
      if (!op[2]) check(req_of(op, 1'b1), result_o, r);
    end
    @(posedge clk);
    if (vld && (op[2] || s)) exp_flags = nxt;
    #1;
    check(vld ? req_of(op, s) : "R9", {28'b0, flags_o}, {28'b0, exp_flags});
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'h7FFF_FFFF;
    vals[3] = 32'h8000_0000; vals[4] = 32'hFFFF_FFFF; vals[5] = 32'hFFFF_FFFC;
    vals[6] = 32'h1234_5678; vals[7] = 32'h0000_FFFA; vals[8] = 32'hFFFF_FFFA;
    #3;
    // R1
    check("R1", {28'b0, flags_o}, '0);
    repeat (2) @(posedge clk);
    #1 rst_ni = 1'b1;

    // R10 directed vectors
    run_op(3'b100, 1'b0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1);
    check("R10", {28'b0, flags_o}, 32'h9);
    run_op(3'b101, 1'b0, 32'h7FFF_FFFF, 32'hFFFF_FFFC, 1'b0, 1'b1);
    check("R10", {28'b0, flags_o}, 32'h2);

    // R11 / R9: idle cycles keep flags
    run_op(3'b100, 1'b0, 32'h0, 32'h1, 1'b1, 1'b0);
    run_op(3'b100, 1'b0, 32'h5, 32'h5, 1'b0, 1'b0);

    for (int o = 0; o < 8; o++)
      for (int s = 0; s < 2; s++)
        for (int i = 0; i < 9; i++)
          for (int j = 0; j < 9; j++)
            run_op(o[2:0], s[0], vals[i], vals[j], ((i + j + s) % 2) == 1, 1'b1);

    // R1 mid-run reset
    run_op(3'b100, 1'b0, 32'h1, 32'h2, 1'b1, 1'b1);
    @(negedge clk);
    rst_ni = 1'b0;
    #1 check("R1", {28'b0, flags_o}, '0);
    exp_flags = '0;
    @(negedge clk);
    rst_ni = 1'b1;
    run_op(3'b110, 1'b0, 32'h0, 32'h0, 1'b1, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule